// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a 4096-word by 12-bit first-in first-out store. Its write side and its read side run on separate clocks. Words enter on the write clock and leave in the same order on the read clock. Each side computes its own flags: full and almost-full on the write side, empty and almost-empty on the read side. Each side works out the occupancy from its own pointer and a two-stage synchronised Gray-coded copy of the other side's pointer. As a result, each flag errs toward the safe side while a pointer change is still crossing.

The two threshold registers are written through the ordinary data input. When `thr_load` is high, the write strobe stores the data word into one of them, and no FIFO write takes place. Each side has its own pointer-clear input. The level of that side's enable during a clear selects the side's mode:
- **Guarded:** full blocks writes and empty blocks reads.
- **Wrapping:** every access is carried out, and the pointers roll over the unread data.

The read data output is a register. It keeps the last word read until the next read is carried out.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers, both threshold registers and `dout` become 0, and both sides enter guarded mode. The flags then read `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1.
- R2: Words are read out in the order they were written. `dout` takes the word on the read-clock edge that performs the read. A single write into an empty FIFO raises `empty_n` after the second read-clock edge that follows the write edge.
- R3: `full_n` is 0 exactly when the write-side occupancy equals 4096. In guarded mode, a write strobe while full is ignored and the word is lost.
- R4: `empty_n` is 0 when the read pointer equals the synchronised write pointer. In guarded mode, a read strobe while empty moves no pointer and leaves `dout` unchanged.
- R5: While `rd_en` is low, `dout` holds its value.
- R6: With N in the almost-full register, `afull_n` is 0 exactly when the write-side occupancy is at least 4096 - N.
- R7: With N in the almost-empty register, `aempty_n` is 1 exactly when the read-side occupancy is greater than N.
- R8: On a write-clock edge with `thr_load`=1 and `wr_en`=1, `din[11:0]` is stored into a threshold register and no word enters the FIFO. `thr_sel`=0 selects the almost-empty register and `thr_sel`=1 selects the almost-full register.
- R9: A write-clock edge with `wr_ptr_clr`=1 zeroes the write pointer and performs no write. If `wr_en` is 0 during that edge, the write side becomes guarded. `rd_ptr_clr` acts the same way on the read side, with `rd_en`=0 selecting guarded.
- R10: A clear taken with the enable at 1 puts that side in wrapping mode. In wrapping mode, every strobe advances the pointer. The 4097th write after the clear lands at address 0 and overwrites the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled in each clock domain |
| wr_en | input | 1 | Write strobe; also chooses the mode during a write-pointer clear |
| wr_ptr_clr | input | 1 | Clears the write pointer |
| thr_load | input | 1 | Routes the write strobe to a threshold register |
| thr_sel | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| din | input | 12 | Write data or threshold value |
| rd_en | input | 1 | Read strobe; also chooses the mode during a read-pointer clear |
| rd_ptr_clr | input | 1 | Clears the read pointer |
| dout | output | 12 | Registered read data |
| full_n | output | 1 | Low when full (write clock) |
| afull_n | output | 1 | Low when almost full (write clock) |
| empty_n | output | 1 | Low when empty (read clock) |
| aempty_n | output | 1 | Low when at or below the almost-empty threshold (read clock) |

## Verification
A pointer that is off by one shows up at the ports as a flag edge that lands one write or one read away from the expected count. The bench checks every flag threshold on the exact cycle on either side of its crossing. A corrupted guard or wrap decision becomes visible only after thousands of cycles, when the data read back after a full-depth fill contains a word that should have been dropped or lacks the one that overwrote address 0. A synchroniser with the wrong depth moves the first `empty_n` rise by one read clock.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic {
        MODE_WRAP  = 1'b0,
        MODE_GUARD = 1'b1
    } side_mode_e;

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wflags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] r;
        r = g;
        for (int i = 30; i >= 0; i--) begin
            r[i] = r[i + 1] ^ g[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Output register doubles as the hold register for the read port.
    always_ff @(posedge rclk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          ptr_clr,
    input  logic          thr_load,
    input  logic          thr_sel,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_sync,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] ae_thr,
    output logic [AW-1:0] af_thr,
    output logic          guard,
    output wflags_t       flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, occ, af_lim;
    logic [AW-1:0] ae_q, af_q;
    side_mode_e    mode_q;
    logic          is_full, wfire, load_hit;

    assign rbin_s   = PW'(gray2bin(32'(rgray_sync)));
    assign occ      = wbin_q - rbin_s;
    assign af_lim   = DEPTH_V - {1'b0, af_q};
    assign is_full  = (occ == DEPTH_V);
    assign load_hit = thr_load && wr_en && !ptr_clr;
    assign wfire    = wr_en && !thr_load && !ptr_clr &&
                      !((mode_q == MODE_GUARD) && is_full);
    assign wbin_nxt = wbin_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            mode_q  <= MODE_GUARD;
            ae_q    <= '0;
            af_q    <= '0;
        end else if (ptr_clr) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            mode_q  <= wr_en ? MODE_WRAP : MODE_GUARD;
        end else begin
            if (load_hit) begin
                if (thr_sel) af_q <= din[AW-1:0];
                else         ae_q <= din[AW-1:0];
            end
            if (wfire) begin
                wbin_q  <= wbin_nxt;
                wgray_q <= PW'(bin2gray(32'(wbin_nxt)));
            end
        end
    end

    assign wbin          = wbin_q;
    assign wgray         = wgray_q;
    assign mem_we        = wfire;
    assign mem_waddr     = wbin_q[AW-1:0];
    assign ae_thr        = ae_q;
    assign af_thr        = af_q;
    assign guard         = (mode_q == MODE_GUARD);
    assign flags.full_n  = !is_full;
    assign flags.afull_n = !(occ >= af_lim);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          ptr_clr,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-1:0] ae_thr_sync,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic          guard,
    output rflags_t       flags
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_s, occ;
    side_mode_e    mode_q;
    logic          is_empty, rfire;

    assign wbin_s   = PW'(gray2bin(32'(wgray_sync)));
    assign occ      = wbin_s - rbin_q;
    assign is_empty = (occ == '0);
    assign rfire    = rd_en && !ptr_clr &&
                      !((mode_q == MODE_GUARD) && is_empty);
    assign rbin_nxt = rbin_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            mode_q  <= MODE_GUARD;
        end else if (ptr_clr) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            mode_q  <= rd_en ? MODE_WRAP : MODE_GUARD;
        end else if (rfire) begin
            rbin_q  <= rbin_nxt;
            rgray_q <= PW'(bin2gray(32'(rbin_nxt)));
        end
    end

    assign rbin           = rbin_q;
    assign rgray          = rgray_q;
    assign mem_re         = rfire;
    assign mem_raddr      = rbin_q[AW-1:0];
    assign guard          = (mode_q == MODE_GUARD);
    assign flags.empty_n  = !is_empty;
    assign flags.aempty_n = (occ > {1'b0, ae_thr_sync});
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcfifo_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_ptr_clr,
    input  logic          thr_load,
    input  logic          thr_sel,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    input  logic          rd_ptr_clr,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          afull_n,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, ae_thr, af_thr, ae_thr_s;
    logic          we, re, w_guard, r_guard;
    wflags_t       wfl;
    rflags_t       rfl;

    dcfifo_wr_ctl #(.AW(AW), .DW(DW)) u_wr (
        .clk(wclk), .rst(rst), .wr_en(wr_en), .ptr_clr(wr_ptr_clr),
        .thr_load(thr_load), .thr_sel(thr_sel), .din(din),
        .rgray_sync(rgray_s), .wbin(wbin), .wgray(wgray),
        .mem_we(we), .mem_waddr(waddr), .ae_thr(ae_thr), .af_thr(af_thr),
        .guard(w_guard), .flags(wfl)
    );

    dcfifo_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wclk), .rst(rst), .d(rgray), .q(rgray_s)
    );

    dcfifo_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rclk), .rst(rst), .d(wgray), .q(wgray_s)
    );

    // Threshold is quasi-static; it is only reloaded while the FIFO is idle.
    dcfifo_sync #(.W(AW), .STAGES(2)) u_thr (
        .clk(rclk), .rst(rst), .d(ae_thr), .q(ae_thr_s)
    );

    dcfifo_rd_ctl #(.AW(AW)) u_rd (
        .clk(rclk), .rst(rst), .rd_en(rd_en), .ptr_clr(rd_ptr_clr),
        .wgray_sync(wgray_s), .ae_thr_sync(ae_thr_s),
        .rbin(rbin), .rgray(rgray), .mem_re(re), .mem_raddr(raddr),
        .guard(r_guard), .flags(rfl)
    );

    dcfifo_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .rclk(rclk), .rst(rst), .re(re), .raddr(raddr), .rdata(dout)
    );

    assign full_n   = wfl.full_n;
    assign afull_n  = wfl.afull_n;
    assign empty_n  = rfl.empty_n;
    assign aempty_n = rfl.aempty_n;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
    parameter int AW = 12,
    parameter int DW = 12
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wr_en,
    input logic          wr_ptr_clr,
    input logic          thr_load,
    input logic          thr_sel,
    input logic [DW-1:0] din,
    input logic          rd_en,
    input logic          rd_ptr_clr,
    input logic [DW-1:0] dout,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rbin,
    input logic          w_guard,
    input logic          r_guard,
    input logic [AW-1:0] af_thr
);
    localparam int PW = AW + 1;

    assert_full_blocks_R3: assert property (@(posedge wclk) disable iff (rst)
        (w_guard && !full_n && wr_en && !thr_load && !wr_ptr_clr) |=> $stable(wbin));

    assert_empty_blocks_R4: assert property (@(posedge rclk) disable iff (rst)
        (r_guard && !empty_n && rd_en && !rd_ptr_clr) |=> ($stable(rbin) && $stable(dout)));

    assert_dout_hold_R5: assert property (@(posedge rclk) disable iff (rst)
        !rd_en |=> $stable(dout));

    assert_full_in_afull_R6: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !afull_n);

    assert_empty_in_aempty_R7: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !aempty_n);

    assert_af_load_R8: assert property (@(posedge wclk) disable iff (rst)
        (thr_load && wr_en && thr_sel && !wr_ptr_clr) |=> (af_thr == $past(din[AW-1:0])));

    assert_wclr_mode_R9: assert property (@(posedge wclk) disable iff (rst)
        wr_ptr_clr |=> ((wbin == '0) && (w_guard == !$past(wr_en))));

    assert_wrap_advance_R10: assert property (@(posedge wclk) disable iff (rst)
        (!w_guard && wr_en && !thr_load && !wr_ptr_clr) |=> (wbin == PW'($past(wbin) + 1'b1)));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.AW(AW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_en(wr_en), .wr_ptr_clr(wr_ptr_clr),
    .thr_load(thr_load), .thr_sel(thr_sel), .din(din), .rd_en(rd_en),
    .rd_ptr_clr(rd_ptr_clr), .dout(dout), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n), .wbin(wbin), .rbin(rbin),
    .w_guard(w_guard), .r_guard(r_guard), .af_thr(af_thr)
);

// File: tb/sim_dcfifo_pflag.sv
module sim_dcfifo_pflag;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_ptr_clr = 1'b0, thr_load = 1'b0, thr_sel = 1'b0;
    logic        rd_en = 1'b0, rd_ptr_clr = 1'b0;
    logic [11:0] din = '0;
    logic [11:0] dout;
    logic        full_n, afull_n, empty_n, aempty_n;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    dcfifo_pflag u0 (
        .wclk(clk), .rclk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr_clr(wr_ptr_clr),
        .thr_load(thr_load), .thr_sel(thr_sel), .din(din), .rd_en(rd_en),
        .rd_ptr_clr(rd_ptr_clr), .dout(dout), .full_n(full_n), .afull_n(afull_n),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    localparam logic [11:0] TBL [12] = '{
        12'h000, 12'hFFF, 12'hAAA, 12'h555, 12'h001, 12'h800,
        12'h0F0, 12'hF0F, 12'h123, 12'hEDC, 12'h7FF, 12'h3C3
    };

    function automatic logic [11:0] pat(input int i);
        return 12'((i * 37) + 12'h1F3);
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        wr_en = 0; rd_en = 0; thr_load = 0; wr_ptr_clr = 0; rd_ptr_clr = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        logic [11:0] held;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        check("R1 empty_n", empty_n, 0);
        check("R1 aempty_n", aempty_n, 0);
        check("R1 full_n", full_n, 1);
        check("R1 afull_n", afull_n, 1);
        check("R1 dout", dout, 0);

        // R2 latency of one write
        wr_en = 1; din = 12'hABC; tick(); wr_en = 0;
        check("R2 empty after write edge", empty_n, 0);
        tick();
        check("R2 empty one edge later", empty_n, 0);
        tick();
        check("R2 empty_n rises", empty_n, 1);
        rd_en = 1; tick(); rd_en = 0;
        check("R2 single word", dout, 12'hABC);
        check("R4 empty after last read", empty_n, 0);
        idle(2);
        check("R5 hold while idle", dout, 12'hABC);
        rd_en = 1; tick(); rd_en = 0;
        check("R4 read when empty holds dout", dout, 12'hABC);

        // R2 table of patterns, written then read in order
        for (int i = 0; i < 12; i++) begin
            wr_en = 1; din = TBL[i]; tick();
        end
        idle(3);
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            rd_en = 1; tick();
            if (dout !== TBL[i]) begin
                bad++;
                $display("FAIL R2 table word %0d actual %0h expected %0h", i, dout, TBL[i]);
            end
        end
        rd_en = 0;
        check("R2 table mismatches", bad, 0);

        // R8 thresholds: almost-full N=16, almost-empty N=5
        thr_load = 1; wr_en = 1; thr_sel = 1; din = 12'd16; tick();
        thr_sel = 0; din = 12'd5; tick();
        thr_load = 0; wr_en = 0;
        idle(3);
        check("R8 load writes no word", empty_n, 0);

        // R3 R6 fill to full
        for (int i = 0; i < 4096; i++) begin
            wr_en = 1; din = pat(i); tick();
            if (i == 4078) check("R6 afull_n one below", afull_n, 1);
            if (i == 4079) check("R6 afull_n at 4080", afull_n, 0);
            if (i == 4094) check("R3 full_n at 4095", full_n, 1);
        end
        check("R3 full_n at 4096", full_n, 0);
        din = 12'h999; tick(); wr_en = 0;
        check("R3 stays full", full_n, 0);
        idle(3);
        check("R7 aempty_n when full", aempty_n, 1);

        // R2 R7 drain
        bad = 0;
        for (int i = 0; i < 4096; i++) begin
            rd_en = 1; tick();
            if (dout !== pat(i)) bad++;
            if (i == 4089) check("R7 aempty_n occupancy 6", aempty_n, 1);
            if (i == 4090) check("R7 aempty_n occupancy 5", aempty_n, 0);
        end
        check("R2 R3 drain mismatches", bad, 0);
        check("R3 write past full dropped", empty_n, 0);
        held = dout;
        tick(); rd_en = 0;
        check("R4 guarded empty read", dout, held);
        idle(3);
        check("R3 full_n recovers", full_n, 1);
        check("R6 afull_n recovers", afull_n, 1);

        // R10 wrapping mode
        wr_ptr_clr = 1; rd_ptr_clr = 1; wr_en = 1; rd_en = 1; tick();
        wr_ptr_clr = 0; rd_ptr_clr = 0; rd_en = 0;
        for (int i = 0; i < 4097; i++) begin
            din = pat(i + 100); tick();
        end
        wr_en = 0;
        idle(3);
        rd_en = 1; tick(); rd_en = 0;
        check("R10 address 0 overwritten", dout, pat(4196));
        rd_en = 1; tick(); rd_en = 0;
        check("R10 next word", dout, pat(101));

        // R9 back to guarded
        wr_ptr_clr = 1; rd_ptr_clr = 1; wr_en = 0; rd_en = 0; tick();
        wr_ptr_clr = 0; rd_ptr_clr = 0;
        idle(3);
        check("R9 empty after clear", empty_n, 0);
        held = dout;
        rd_en = 1; tick(); rd_en = 0;
        check("R9 guarded read blocked", dout, held);
        wr_en = 1; din = 12'h4D2; tick(); wr_en = 0;
        idle(3);
        rd_en = 1; tick(); rd_en = 0;
        check("R9 first word after clear", dout, 12'h4D2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule